// File: doc/BRIEF.md
# Early Partial-Address Load Disambiguation Unit

This block sits at the front of the load/store queue of a clustered core. The effective address of a load travels to the queue over two links. A fast, narrow link delivers only the low-order bits. A slower, full-width link delivers the whole address some cycles later. The unit keeps the in-flight stores in program order. As soon as the low-order bits of a load land, it does two things at once. It compares those bits against every older store and gives a speculative dependence verdict, and it sends a cache set index taken from the same bits, so that the data and tag arrays can be read early.

When the full load address arrives, the unit redoes the check with complete addresses. The result confirms a forward from the youngest older store that matches, or it clears a dependence that came only from aliasing of the low-order bits, or it asks the load to wait because an older store still has an unknown address. A load whose low bits match an older store is always treated as dependent at first. False dependences are accepted and then removed once the full comparison is done.

Stores are allocated at the tail of a circular queue. Each store receives its low bits and its full address and data on separate ports, and stores leave from the head. A flush empties the queue and drops the load that is being resolved.

Top module: `ed_disamb_unit`

## Requirements
- R1: After reset or a cycle with `flush` high, the queue is empty (`st_ins_id` = 0, `st_full` = 0), `ld_busy` is 0, and the outputs `early_idx_vld`, `spec_vld` and `fin_vld` are low.
- R2: A store insert is placed at the tail. `st_ins_id` gives the slot it takes, and slots advance 0..DEPTH-1 and wrap. With DEPTH stores held, `st_full` is 1 and an insert is ignored, so the slot id does not move.
- R3: One cycle after an accepted `ld_lo_vld`, `early_idx_vld` pulses with `early_idx` = `ld_lo_addr[IDX_LO +: IDX_W]`, which is bits [7:2] by default.
- R4: One cycle after an accepted `ld_lo_vld`, `spec_vld` pulses. `spec_res` = 1 (match) with `spec_id` = the youngest older store whose known low bits equal `ld_lo_addr`. This also holds across pointer wrap.
- R5: If any older store has no known address bits, `spec_res` = 2 (wait). Otherwise, if no older store matches, `spec_res` = 0 (go). Wait takes priority over match.
- R6: The only stores counted as older are those inserted before the load. `ld_age` is the number of inserts since reset or flush, modulo 2*DEPTH. Younger stores have no effect.
- R7: One cycle after `ld_full_vld` while a load is pending, `fin_vld` pulses. `fin_res` = 1 with `fin_id`, and `fin_data` = data of the youngest older store whose full address equals `ld_full_addr`.
- R8: If the speculative verdict was a match but the full comparison finds no match, then `fin_res` = 0 and `fin_false_dep` = 1.
- R9: If an older store has no full address yet, `fin_res` = 2 and the load stays pending (`ld_busy` = 1). A later `ld_full_vld` retries it.
- R10: `st_ret_vld` removes the head store. A retired store no longer takes part in either comparison.
- R11: `flush` cancels a pending load. A `ld_lo_vld` in the same cycle as `flush` gives neither an early index nor a verdict.
- R12: `ld_lo_vld` while a load is pending, and `ld_full_vld` while none is pending, are ignored and produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and drop the pending load |
| st_ins_vld | input | 1 | Allocate a store at the tail |
| st_ins_id | output | PTR_W | Slot the next store will take |
| st_full | output | 1 | Queue holds DEPTH stores |
| st_lo_vld | input | 1 | Low address bits known for a store |
| st_lo_id | input | PTR_W | Slot receiving low bits |
| st_lo_addr | input | PART_W | Store low address bits |
| st_addr_vld | input | 1 | Full address and data known for a store |
| st_addr_id | input | PTR_W | Slot receiving full address |
| st_addr | input | ADDR_W | Store full address |
| st_data | input | DATA_W | Store data |
| st_ret_vld | input | 1 | Retire the head store |
| ld_lo_vld | input | 1 | Early low bits of a load |
| ld_lo_addr | input | PART_W | Load low address bits |
| ld_age | input | PTR_W+1 | Store-insert count when the load was dispatched |
| ld_full_vld | input | 1 | Full load address present |
| ld_full_addr | input | ADDR_W | Load full address |
| early_idx_vld | output | 1 | Early cache index valid |
| early_idx | output | IDX_W | Cache set index from low bits |
| spec_vld | output | 1 | Speculative verdict valid |
| spec_res | output | 2 | 0 go, 1 match, 2 wait |
| spec_id | output | PTR_W | Matched store slot |
| fin_vld | output | 1 | Final verdict valid |
| fin_res | output | 2 | 0 go, 1 match, 2 wait |
| fin_id | output | PTR_W | Forwarding store slot |
| fin_data | output | DATA_W | Forwarded store data |
| fin_false_dep | output | 1 | Partial match cleared by full compare |
| ld_busy | output | 1 | A load is pending |

## Verification
The hardest situations to reach are those where the age window of a load crosses the wrap point of the store pointers, and those where the partial and full verdicts differ. Aliased low bits and stores that are only partly resolved produce these cases. The stimulus fills the queue to DEPTH so that slot ids wrap. It then retires stores so that a newly inserted store lands in a wrapped slot and holds the only full match for a load. The stimulus also gives stores low bits that alias with different upper bits, and it holds back one store's full address while its low bits are already known. This drives the unit through wait, retry, forward and false-dependence outcomes in turn.

// File: rtl/ed_pkg.sv
package ed_pkg;
  typedef enum logic [1:0] {
    RES_GO    = 2'd0,
    RES_MATCH = 2'd1,
    RES_WAIT  = 2'd2
  } res_e;
endpackage

// File: rtl/ed_store_queue.sv
module ed_store_queue #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int PART_W = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic                               ins_vld,
  output logic [PTR_W-1:0]                   ins_id,
  output logic                               full,
  input  logic                               lo_vld,
  input  logic [PTR_W-1:0]                   lo_id,
  input  logic [PART_W-1:0]                  lo_addr,
  input  logic                               addr_vld,
  input  logic [PTR_W-1:0]                   addr_id,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  data,
  input  logic                               ret_vld,
  output logic [PTR_W:0]                     head_ptr,
  output logic [DEPTH-1:0]                   ent_vld,
  output logic [DEPTH-1:0]                   ent_lo_ok,
  output logic [DEPTH-1:0]                   ent_full_ok,
  output logic [DEPTH-1:0][PART_W-1:0]       ent_lo,
  output logic [DEPTH-1:0][ADDR_W-1:0]       ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]       ent_data
);
  localparam logic [PTR_W:0] CAP = (PTR_W+1)'(DEPTH);

  logic [PTR_W:0]   head_q, head_d, tail_q, tail_d, used;
  logic [DEPTH-1:0] vld_q, vld_d, lo_ok_q, lo_ok_d, fok_q, fok_d;
  logic [DEPTH-1:0][PART_W-1:0] lo_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic do_ins, do_ret, lo_wr, addr_wr;

  assign used    = tail_q - head_q;
  assign full    = (used == CAP);
  assign do_ins  = ins_vld && !full && !flush;
  assign do_ret  = ret_vld && (used != '0) && !flush;
  assign lo_wr   = lo_vld && vld_q[lo_id] && !flush;
  assign addr_wr = addr_vld && vld_q[addr_id] && !flush;

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    vld_d   = vld_q;
    lo_ok_d = lo_ok_q;
    fok_d   = fok_q;
    if (lo_wr) lo_ok_d[lo_id] = 1'b1;
    if (addr_wr) begin
      lo_ok_d[addr_id] = 1'b1;
      fok_d[addr_id]   = 1'b1;
    end
    if (do_ret) begin
      vld_d[head_q[PTR_W-1:0]]   = 1'b0;
      lo_ok_d[head_q[PTR_W-1:0]] = 1'b0;
      fok_d[head_q[PTR_W-1:0]]   = 1'b0;
      head_d = head_q + 1'b1;
    end
    if (do_ins) begin
      vld_d[tail_q[PTR_W-1:0]]   = 1'b1;
      lo_ok_d[tail_q[PTR_W-1:0]] = 1'b0;
      fok_d[tail_q[PTR_W-1:0]]   = 1'b0;
      tail_d = tail_q + 1'b1;
    end
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      vld_d   = '0;
      lo_ok_d = '0;
      fok_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      vld_q   <= '0;
      lo_ok_q <= '0;
      fok_q   <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      vld_q   <= vld_d;
      lo_ok_q <= lo_ok_d;
      fok_q   <= fok_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (addr_wr && (addr_id == PTR_W'(g))) begin
        addr_q[g] <= addr;
        data_q[g] <= data;
        lo_q[g]   <= addr[PART_W-1:0];
      end else if (lo_wr && (lo_id == PTR_W'(g))) begin
        lo_q[g] <= lo_addr;
      end
    end
  end

  assign ins_id      = tail_q[PTR_W-1:0];
  assign head_ptr    = head_q;
  assign ent_vld     = vld_q;
  assign ent_lo_ok   = lo_ok_q;
  assign ent_full_ok = fok_q;
  assign ent_lo      = lo_q;
  assign ent_addr    = addr_q;
  assign ent_data    = data_q;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= CAP);
  assert_full_holds_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ret_vld && !flush) |=> $stable(tail_q));
  assert_retire_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !flush && (tail_q != head_q)) |=> !vld_q[$past(head_q[PTR_W-1:0])]);
  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((vld_q == '0) && (head_q == tail_q)));
endmodule

// File: rtl/ed_age_match.sv
module ed_age_match #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W:0]              head_ptr,
  input  logic [PTR_W:0]              older_ptr,
  input  logic [DEPTH-1:0]            ent_vld,
  input  logic [DEPTH-1:0]            ent_ok,
  input  logic [DEPTH-1:0][KEY_W-1:0] ent_key,
  input  logic [KEY_W-1:0]            probe,
  output logic                        hit,
  output logic [PTR_W-1:0]            hit_id,
  output logic                        blocked
);
  logic [PTR_W:0] span;
  assign span = older_ptr - head_ptr;

  // Walk from oldest to youngest; a later match overrides, so the youngest wins.
  always_comb begin
    hit     = 1'b0;
    hit_id  = '0;
    blocked = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTR_W-1:0] idx;
      idx = head_ptr[PTR_W-1:0] + PTR_W'(k);
      if (((PTR_W+1)'(k) < span) && ent_vld[idx]) begin
        if (!ent_ok[idx]) begin
          blocked = 1'b1;
        end else if (ent_key[idx] == probe) begin
          hit    = 1'b1;
          hit_id = idx;
        end
      end
    end
  end
endmodule

// File: rtl/ed_load_ctrl.sv
module ed_load_ctrl
  import ed_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_lo_vld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [PTR_W:0]    ld_age,
  input  logic              ld_full_vld,
  input  logic              p_hit,
  input  logic [PTR_W-1:0]  p_id,
  input  logic              p_blk,
  input  logic              f_hit,
  input  logic [PTR_W-1:0]  f_id,
  input  logic              f_blk,
  input  logic [DATA_W-1:0] f_data,
  output logic [PTR_W:0]    age_q,
  output logic              early_idx_vld,
  output logic [IDX_W-1:0]  early_idx,
  output logic              spec_vld,
  output logic [1:0]        spec_res,
  output logic [PTR_W-1:0]  spec_id,
  output logic              fin_vld,
  output logic [1:0]        fin_res,
  output logic [PTR_W-1:0]  fin_id,
  output logic [DATA_W-1:0] fin_data,
  output logic              fin_false_dep,
  output logic              ld_busy
);
  logic lo_take, full_take;
  logic busy_q, busy_d, smatch_q, smatch_d;
  logic early_vld_d, spec_vld_d, fin_vld_d, false_q, false_d;
  logic early_vld_q, spec_vld_q, fin_vld_q;
  res_e spec_res_d, spec_res_q, fin_res_d, fin_res_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PTR_W-1:0]  sid_q, fid_q;
  logic [DATA_W-1:0] fdata_q;

  assign lo_take   = ld_lo_vld && !busy_q && !flush;
  assign full_take = ld_full_vld && busy_q && !flush;

  always_comb begin
    spec_res_d  = p_blk ? RES_WAIT : (p_hit ? RES_MATCH : RES_GO);
    fin_res_d   = f_blk ? RES_WAIT : (f_hit ? RES_MATCH : RES_GO);
    early_vld_d = lo_take;
    spec_vld_d  = lo_take;
    fin_vld_d   = full_take;
    false_d     = full_take && smatch_q && (fin_res_d == RES_GO);
    smatch_d    = lo_take ? (spec_res_d == RES_MATCH) : smatch_q;
    busy_d      = busy_q;
    if (lo_take) busy_d = 1'b1;
    if (full_take && (fin_res_d != RES_WAIT)) busy_d = 1'b0;
    if (flush) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      smatch_q    <= 1'b0;
      early_vld_q <= 1'b0;
      spec_vld_q  <= 1'b0;
      fin_vld_q   <= 1'b0;
      false_q     <= 1'b0;
      spec_res_q  <= RES_GO;
      fin_res_q   <= RES_GO;
    end else begin
      busy_q      <= busy_d;
      smatch_q    <= smatch_d;
      early_vld_q <= early_vld_d;
      spec_vld_q  <= spec_vld_d;
      fin_vld_q   <= fin_vld_d;
      false_q     <= false_d;
      if (lo_take)   spec_res_q <= spec_res_d;
      if (full_take) fin_res_q  <= fin_res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_take) begin
      idx_q <= ld_idx;
      sid_q <= p_id;
      age_q <= ld_age;
    end
    if (full_take) begin
      fid_q   <= f_id;
      fdata_q <= f_data;
    end
  end

  assign early_idx_vld = early_vld_q;
  assign early_idx     = idx_q;
  assign spec_vld      = spec_vld_q;
  assign spec_res      = spec_res_q;
  assign spec_id       = sid_q;
  assign fin_vld       = fin_vld_q;
  assign fin_res       = fin_res_q;
  assign fin_id        = fid_q;
  assign fin_data      = fdata_q;
  assign fin_false_dep = false_q;
  assign ld_busy       = busy_q;

  assert_fin_needs_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |-> $past(busy_q));
  assert_no_dual_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spec_vld |-> !fin_vld);
  assert_wait_stays_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_vld && (fin_res == RES_WAIT)) |-> ld_busy);
  assert_false_means_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_false_dep |-> (fin_vld && (fin_res == RES_GO)));
  assert_flush_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ld_busy && !early_idx_vld && !spec_vld && !fin_vld));
  assert_early_with_spec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    early_idx_vld |-> (spec_vld && ld_busy));
endmodule

// File: rtl/ed_disamb_unit.sv
module ed_disamb_unit #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int PART_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              st_ins_vld,
  output logic [PTR_W-1:0]  st_ins_id,
  output logic              st_full,
  input  logic              st_lo_vld,
  input  logic [PTR_W-1:0]  st_lo_id,
  input  logic [PART_W-1:0] st_lo_addr,
  input  logic              st_addr_vld,
  input  logic [PTR_W-1:0]  st_addr_id,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_ret_vld,
  input  logic              ld_lo_vld,
  input  logic [PART_W-1:0] ld_lo_addr,
  input  logic [PTR_W:0]    ld_age,
  input  logic              ld_full_vld,
  input  logic [ADDR_W-1:0] ld_full_addr,
  output logic              early_idx_vld,
  output logic [IDX_W-1:0]  early_idx,
  output logic              spec_vld,
  output logic [1:0]        spec_res,
  output logic [PTR_W-1:0]  spec_id,
  output logic              fin_vld,
  output logic [1:0]        fin_res,
  output logic [PTR_W-1:0]  fin_id,
  output logic [DATA_W-1:0] fin_data,
  output logic              fin_false_dep,
  output logic              ld_busy
);
  logic [PTR_W:0]                   head_ptr, age_q;
  logic [DEPTH-1:0]                 ent_vld, ent_lo_ok, ent_full_ok;
  logic [DEPTH-1:0][PART_W-1:0]     ent_lo;
  logic [DEPTH-1:0][ADDR_W-1:0]     ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0]     ent_data;
  logic p_hit, p_blk, f_hit, f_blk;
  logic [PTR_W-1:0] p_id, f_id;

  ed_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PART_W(PART_W), .DATA_W(DATA_W)) u_stq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_vld(st_ins_vld), .ins_id(st_ins_id), .full(st_full),
    .lo_vld(st_lo_vld), .lo_id(st_lo_id), .lo_addr(st_lo_addr),
    .addr_vld(st_addr_vld), .addr_id(st_addr_id), .addr(st_addr), .data(st_data),
    .ret_vld(st_ret_vld), .head_ptr(head_ptr),
    .ent_vld(ent_vld), .ent_lo_ok(ent_lo_ok), .ent_full_ok(ent_full_ok),
    .ent_lo(ent_lo), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  ed_age_match #(.DEPTH(DEPTH), .KEY_W(PART_W)) u_part_cmp (
    .head_ptr(head_ptr), .older_ptr(ld_age), .ent_vld(ent_vld), .ent_ok(ent_lo_ok),
    .ent_key(ent_lo), .probe(ld_lo_addr), .hit(p_hit), .hit_id(p_id), .blocked(p_blk)
  );

  ed_age_match #(.DEPTH(DEPTH), .KEY_W(ADDR_W)) u_full_cmp (
    .head_ptr(head_ptr), .older_ptr(age_q), .ent_vld(ent_vld), .ent_ok(ent_full_ok),
    .ent_key(ent_addr), .probe(ld_full_addr), .hit(f_hit), .hit_id(f_id), .blocked(f_blk)
  );

  ed_load_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ldc (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_lo_vld(ld_lo_vld), .ld_idx(ld_lo_addr[IDX_LO +: IDX_W]), .ld_age(ld_age),
    .ld_full_vld(ld_full_vld),
    .p_hit(p_hit), .p_id(p_id), .p_blk(p_blk),
    .f_hit(f_hit), .f_id(f_id), .f_blk(f_blk), .f_data(ent_data[f_id]),
    .age_q(age_q),
    .early_idx_vld(early_idx_vld), .early_idx(early_idx),
    .spec_vld(spec_vld), .spec_res(spec_res), .spec_id(spec_id),
    .fin_vld(fin_vld), .fin_res(fin_res), .fin_id(fin_id), .fin_data(fin_data),
    .fin_false_dep(fin_false_dep), .ld_busy(ld_busy)
  );
endmodule

// File: tb/ed_disamb_unit_tb_top.sv
module ed_disamb_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flush = 0, st_ins_vld = 0, st_lo_vld = 0, st_addr_vld = 0, st_ret_vld = 0;
  logic ld_lo_vld = 0, ld_full_vld = 0;
  logic [3:0] st_lo_id = 0, st_addr_id = 0, st_ins_id, spec_id, fin_id;
  logic [7:0] st_lo_addr = 0, ld_lo_addr = 0;
  logic [31:0] st_addr = 0, st_data = 0, ld_full_addr = 0, fin_data;
  logic [4:0] ld_age = 0;
  logic st_full, early_idx_vld, spec_vld, fin_vld, fin_false_dep, ld_busy;
  logic [5:0] early_idx;
  logic [1:0] spec_res, fin_res;

  ed_disamb_unit dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench-side store model
  bit m_vld[16], m_lok[16], m_fok[16];
  logic [7:0]  m_lo[16];
  logic [31:0] m_addr[16], m_data[16];
  int m_head = 0, m_tail = 0;
  int b_age = 0;
  bit b_specmatch = 0;

  logic [5:0]  q_early[$];
  logic [5:0]  q_spec[$];
  logic [38:0] q_fin[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] m_eval(input int age, input logic [31:0] probe,
                                        input bit fullcmp, output int id);
    int span;
    bit blk, hit;
    span = (age - m_head) & 31;
    blk = 0; hit = 0; id = 0;
    for (int k = 0; k < 16; k++) begin
      int ix;
      ix = (m_head + k) % 16;
      if (k < span && m_vld[ix]) begin
        if (!(fullcmp ? m_fok[ix] : m_lok[ix])) blk = 1;
        else if (fullcmp ? (m_addr[ix] == probe) : (m_lo[ix] == probe[7:0])) begin
          hit = 1; id = ix;
        end
      end
    end
    return blk ? 2'd2 : (hit ? 2'd1 : 2'd0);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ins_store(output int id);
    chk(st_ins_id == 4'(m_tail % 16), "R2", "ins_id", st_ins_id, m_tail % 16);
    id = m_tail % 16;
    st_ins_vld = 1; step(); st_ins_vld = 0;
    m_vld[id] = 1; m_lok[id] = 0; m_fok[id] = 0;
    m_tail = (m_tail + 1) % 32;
  endtask

  task automatic set_lo(input int id, input logic [7:0] lo);
    st_lo_vld = 1; st_lo_id = 4'(id); st_lo_addr = lo; step(); st_lo_vld = 0;
    m_lok[id] = 1; m_lo[id] = lo;
  endtask

  task automatic set_full(input int id, input logic [31:0] a, input logic [31:0] d);
    st_addr_vld = 1; st_addr_id = 4'(id); st_addr = a; st_data = d; step(); st_addr_vld = 0;
    m_lok[id] = 1; m_fok[id] = 1; m_lo[id] = a[7:0]; m_addr[id] = a; m_data[id] = d;
  endtask

  task automatic retire();
    st_ret_vld = 1; step(); st_ret_vld = 0;
    m_vld[m_head % 16] = 0;
    m_head = (m_head + 1) % 32;
  endtask

  // R6: age is the bench's own insert count; pass -1 to use current count
  task automatic load_early(input logic [7:0] lo, input int age);
    int id; logic [1:0] r;
    b_age = (age < 0) ? m_tail : age;
    r = m_eval(b_age, {24'h0, lo}, 0, id);
    q_early.push_back(lo[7:2]);
    q_spec.push_back({r, (r == 2'd1) ? 4'(id) : 4'd0});
    b_specmatch = (r == 2'd1);
    ld_lo_vld = 1; ld_lo_addr = lo; ld_age = 5'(b_age); step(); ld_lo_vld = 0;
  endtask

  task automatic load_full(input logic [31:0] a);
    int id; logic [1:0] r; bit fd;
    r = m_eval(b_age, a, 1, id);
    fd = b_specmatch && (r == 2'd0);
    q_fin.push_back({fd, r, (r == 2'd1) ? 4'(id) : 4'd0, (r == 2'd1) ? m_data[id] : 32'd0});
    ld_full_vld = 1; ld_full_addr = a; step(); ld_full_vld = 0;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) if (rst_n && !done) begin
    if (early_idx_vld) begin
      if (q_early.size() == 0) chk(0, "R11/R12", "unexpected early_idx", 1, 0);
      else begin
        logic [5:0] e; e = q_early.pop_front();
        chk(early_idx == e, "R3", "early_idx", early_idx, e);
      end
    end
    if (spec_vld) begin
      if (q_spec.size() == 0) chk(0, "R12", "unexpected spec", 1, 0);
      else begin
        logic [5:0] e; logic [3:0] aid; e = q_spec.pop_front();
        aid = (spec_res == 2'd1) ? spec_id : 4'd0;
        chk({spec_res, aid} == e, "R4/R5", "spec res,id", {spec_res, aid}, e);
      end
    end
    if (fin_vld) begin
      if (q_fin.size() == 0) chk(0, "R12", "unexpected fin", 1, 0);
      else begin
        logic [38:0] e, a; e = q_fin.pop_front();
        a = {fin_false_dep, fin_res, (fin_res == 2'd1) ? fin_id : 4'd0,
             (fin_res == 2'd1) ? fin_data : 32'd0};
        chk(a == e, "R7/R8/R9", "fin false,res,id,data", a, e);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_up();
  end

  initial begin
    int s0, s1, s2, s3, tmp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    chk(st_ins_id == 0 && !st_full, "R1", "queue empty after reset", {st_full, st_ins_id}, 0);
    chk(!ld_busy && !early_idx_vld && !spec_vld && !fin_vld, "R1", "outputs idle",
        {ld_busy, early_idx_vld, spec_vld, fin_vld}, 0);

    ins_store(s0); ins_store(s1); ins_store(s2);
    set_full(s0, 32'h1000_0010, 32'hAAAA_0000);
    set_full(s1, 32'h2000_0034, 32'hBBBB_0001);

    // R5: s2 unknown -> wait; R9: final wait then retry
    load_early(8'h34, -1);
    step();
    load_full(32'h2000_0034);
    step();
    chk(ld_busy == 1, "R9", "busy after wait", ld_busy, 1);
    set_lo(s2, 8'h77);
    set_full(s2, 32'h3000_0077, 32'hCCCC_0002);
    load_full(32'h2000_0034);   // R7 forward from s1
    step();
    chk(ld_busy == 0, "R7", "load done", ld_busy, 0);

    // R8: partial alias with s0 cleared by full address
    load_early(8'h10, -1);
    load_full(32'h5000_0010);
    step();

    // R4: youngest older match wins
    ins_store(s3);
    set_full(s3, 32'h2000_0034, 32'hDDDD_0003);
    load_early(8'h34, -1);
    load_full(32'h2000_0034);
    step();

    // R6: load older than s1..s3 sees only s0
    load_early(8'h34, 1);
    load_full(32'h2000_0034);
    step();

    // R12: second early ignored while busy, full ignored while idle
    load_early(8'h10, -1);
    ld_lo_vld = 1; ld_lo_addr = 8'h77; step(); ld_lo_vld = 0;
    load_full(32'h1000_0010);
    step();
    ld_full_vld = 1; ld_full_addr = 32'h1000_0010; step(); ld_full_vld = 0;
    step();
    chk(ld_busy == 0, "R12", "idle full ignored", ld_busy, 0);

    // R10: retired stores drop out
    retire(); retire();
    load_early(8'h10, -1);
    load_full(32'h1000_0010);
    step();

    // R2: fill to capacity with wrap
    for (int n = 0; n < 14; n++) begin
      ins_store(tmp);
      set_full(tmp, 32'h4000_0100 + 32'(n), 32'(n));
    end
    chk(st_full == 1, "R2", "full at DEPTH", st_full, 1);
    st_ins_vld = 1; step(); st_ins_vld = 0;
    chk(st_ins_id == 4'(m_tail % 16), "R2", "ins ignored when full", st_ins_id, m_tail % 16);
    retire();
    chk(st_full == 0, "R2", "not full after retire", st_full, 0);
    ins_store(tmp);
    set_full(tmp, 32'h7000_00C4, 32'hEEEE_0004);
    load_early(8'hC4, -1);     // R4 across wrap
    load_full(32'h7000_00C4);
    step();

    // R11: flush cancels pending load
    load_early(8'h34, -1);
    flush = 1; step(); flush = 0;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_lok[i] = 0; m_fok[i] = 0; end
    m_head = 0; m_tail = 0;
    chk(!ld_busy && st_ins_id == 0 && !st_full, "R11", "flush clears",
        {ld_busy, st_full, st_ins_id}, 0);
    ld_full_vld = 1; step(); ld_full_vld = 0;
    flush = 1; ld_lo_vld = 1; ld_lo_addr = 8'h34; step(); flush = 0; ld_lo_vld = 0;
    step(); step();
    chk(!ld_busy, "R11", "early with flush dropped", ld_busy, 0);
    chk(q_early.size() == 0 && q_spec.size() == 0 && q_fin.size() == 0, "R3",
        "scoreboard drained", q_early.size() + q_spec.size() + q_fin.size(), 0);
    finish_up();
  end
endmodule